// File: doc/BRIEF.md
# Flash Read Wait-State Emulation Unit

This unit sits in the read path of a flash controller's AHB slave port. It lets slow memory timing be emulated on the bus. Each accepted transfer carries a 5-bit delay field in its upper address bits. When that field is zero, reads run at the controller's normal speed. A page-buffer hit then completes with no wait state, and a miss costs the fixed array latency. A read miss of this kind also asks the page buffer to prefetch the next line.

When the delay field is non-zero, the unit treats the page buffer as absent. A reported hit is handled as a miss, no prefetch request is raised, and an inhibit flag is driven to the buffer logic for the whole data phase. On the first beat of a read (NONSEQ), the field value is added to the array latency as extra wait states. The later beats of a burst (SEQ) pay only the array latency. Writes always take their own fixed latency, whatever the field or hit inputs say.

The flash array is stood in for by a fixed-latency responder inside the unit. It returns the transfer address XORed with a parameter key. The delay field and the transfer kind are captured in the address phase. Address lines that change later have no effect on the transfer already in its data phase. The array latency parameter must be at least 1.

Top module: `flash_rd_ws_emu`

## Requirements
- R1: While reset is asserted and after its release, with no transfer taken, hready_o is 1, and hrdata_o, pf_inhibit_o and pf_req_o are 0.
- R2: A read whose field haddr_i[28:24] is 0 and whose buf_hit_i is 1 in the address phase completes with 0 wait states.
- R3: A read whose field is 0 and whose buf_hit_i is 0 completes with ARR_WS wait states (default 2), in NONSEQ (htrans_i=2'b10) or SEQ (2'b11).
- R4: A NONSEQ read with a non-zero field F takes ARR_WS+F wait states, ignoring buf_hit_i, so at most ARR_WS+31 wait states.
- R5: A SEQ read with a non-zero field takes ARR_WS wait states, with no added cycles and with buf_hit_i ignored.
- R6: A write (hwrite_i=1) takes WR_WS wait states (default 1), regardless of the field value and of buf_hit_i.
- R7: In the cycle where a read data phase ends with hready_o high, hrdata_o equals the captured address XOR DATA_KEY (default 32'h5A3C96E1). In every other cycle, hrdata_o is 0.
- R8: pf_inhibit_o is 1 in every cycle of the data phase of a read with a non-zero field, and 0 otherwise.
- R9: pf_req_o pulses for exactly one cycle, in the final data-phase cycle of a read with a zero field and a buffer miss. It never rises for writes, for hits or for reads with a non-zero field.
- R10: The wait count and the transfer kind are fixed in the address phase. Changing haddr_i, hwrite_i or buf_hit_i during the wait states does not alter them.
- R11: A cycle with hsel_i low, or with htrans_i IDLE (2'b00) or BUSY (2'b01), starts no data phase, and hready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel_i | input | 1 | Slave select |
| htrans_i | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite_i | input | 1 | 1 = write transfer |
| haddr_i | input | AW (32) | Transfer address; bits 28:24 hold the delay field |
| buf_hit_i | input | 1 | Page buffer hit for the address-phase transfer |
| hready_o | output | 1 | Stretched transfer-done signal |
| hrdata_o | output | DW (32) | Read data, valid when hready_o is high |
| pf_inhibit_o | output | 1 | Page buffer bypass during an emulated read |
| pf_req_o | output | 1 | Next-line prefetch request pulse |

## Verification
The assertions assume that ARR_WS is at least 1, so that two prefetch pulses can never fall in adjacent cycles. They also assume the master treats hready_o as the only end of a data phase, so every low hready_o cycle belongs to one transfer whose inhibit flag cannot change. The stimulus issues one transfer at a time and waits for hready_o before the next address phase. During wait states it deselects the slave and drives random values on the address, write and hit lines. The protocol assumptions therefore hold, and R10 is still exercised.

// File: rtl/rwe_pkg.sv
package rwe_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [2:0] {
    XK_WRITE     = 3'd0,
    XK_RD_HIT    = 3'd1,
    XK_RD_MISS   = 3'd2,
    XK_EMU_FIRST = 3'd3,
    XK_EMU_BEAT  = 3'd4
  } xfer_kind_e;

  function automatic logic kind_is_emu(input xfer_kind_e k);
    return (k == XK_EMU_FIRST) || (k == XK_EMU_BEAT);
  endfunction

endpackage

// File: rtl/rwe_decode.sv
module rwe_decode
  import rwe_pkg::*;
#(
  parameter int FIELD_W = 5,
  parameter int ARR_WS  = 2,
  parameter int WR_WS   = 1,
  parameter int CNT_W   = 6
) (
  input  logic               hsel_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               buf_hit_i,
  input  logic               ready_i,
  output logic               accept_o,
  output xfer_kind_e         kind_o,
  output logic [CNT_W-1:0]   wait_o
);

  htrans_e tr;
  logic    emu;

  always_comb begin
    tr       = htrans_e'(htrans_i);
    accept_o = hsel_i && (tr == TR_NONSEQ || tr == TR_SEQ) && ready_i;
    emu      = (field_i != '0);

    if (hwrite_i)       kind_o = XK_WRITE;
    else if (!emu)      kind_o = buf_hit_i ? XK_RD_HIT : XK_RD_MISS;
    else if (tr == TR_SEQ) kind_o = XK_EMU_BEAT;
    else                kind_o = XK_EMU_FIRST;

    unique case (kind_o)
      XK_WRITE:     wait_o = CNT_W'(WR_WS);
      XK_RD_HIT:    wait_o = '0;
      XK_EMU_FIRST: wait_o = CNT_W'(ARR_WS) + CNT_W'(field_i);
      default:      wait_o = CNT_W'(ARR_WS);
    endcase
  end

endmodule

// File: rtl/rwe_phase_reg.sv
module rwe_phase_reg
  import rwe_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready_i,
  input  logic          accept_i,
  input  xfer_kind_e    kind_i,
  input  logic [AW-1:0] addr_i,
  output logic          dp_valid_o,
  output xfer_kind_e    dp_kind_o,
  output logic [AW-1:0] dp_addr_o
);

  logic          valid_d;
  logic          cap_en;
  xfer_kind_e    kind_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    cap_en  = accept_i;
    valid_d = ready_i ? accept_i : dp_valid_o;
    kind_d  = cap_en ? kind_i : dp_kind_o;
    addr_d  = cap_en ? addr_i : dp_addr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid_o <= 1'b0;
      dp_kind_o  <= XK_RD_HIT;
      dp_addr_o  <= '0;
    end else begin
      dp_valid_o <= valid_d;
      if (cap_en) begin
        dp_kind_o <= kind_d;
        dp_addr_o <= addr_d;
      end
    end
  end

endmodule

// File: rtl/rwe_wait_ctr.sv
module rwe_wait_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             active_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    zero_o = (cnt_q == '0);
    cnt_en = load_i || (active_i && !zero_o);
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rwe_resp.sv
module rwe_resp
  import rwe_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter logic [DW-1:0] DATA_KEY = 32'h5A3C_96E1
) (
  input  logic          dp_valid_i,
  input  xfer_kind_e    dp_kind_i,
  input  logic [AW-1:0] dp_addr_i,
  input  logic          done_i,
  output logic          hready_o,
  output logic [DW-1:0] hrdata_o,
  output logic          pf_inhibit_o,
  output logic          pf_req_o
);

  logic          rd_phase;
  logic [DW-1:0] arr_word;

  generate
    if (DW <= AW) begin : g_narrow
      assign arr_word = dp_addr_i[DW-1:0] ^ DATA_KEY;
    end else begin : g_wide
      assign arr_word = {{(DW-AW){1'b0}}, dp_addr_i} ^ DATA_KEY;
    end
  endgenerate

  always_comb begin
    rd_phase     = dp_valid_i && (dp_kind_i != XK_WRITE);
    hready_o     = !dp_valid_i || done_i;
    hrdata_o     = (rd_phase && done_i) ? arr_word : '0;
    pf_inhibit_o = dp_valid_i && kind_is_emu(dp_kind_i);
    pf_req_o     = dp_valid_i && (dp_kind_i == XK_RD_MISS) && done_i;
  end

endmodule

// File: rtl/flash_rd_ws_emu.sv
module flash_rd_ws_emu
  import rwe_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            FIELD_LSB = 24,
  parameter int            FIELD_W   = 5,
  parameter int            ARR_WS    = 2,
  parameter int            WR_WS     = 1,
  parameter logic [DW-1:0] DATA_KEY  = 32'h5A3C_96E1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel_i,
  input  logic [1:0]    htrans_i,
  input  logic          hwrite_i,
  input  logic [AW-1:0] haddr_i,
  input  logic          buf_hit_i,
  output logic          hready_o,
  output logic [DW-1:0] hrdata_o,
  output logic          pf_inhibit_o,
  output logic          pf_req_o
);

  localparam int EMU_MAX = ARR_WS + (1 << FIELD_W) - 1;
  localparam int MAX_WS  = (EMU_MAX > WR_WS) ? EMU_MAX : WR_WS;
  localparam int CNT_W   = $clog2(MAX_WS + 1);

  logic               accept;
  xfer_kind_e         kind;
  logic [CNT_W-1:0]   wait_val;
  logic               dp_valid;
  xfer_kind_e         dp_kind;
  logic [AW-1:0]      dp_addr;
  logic               cnt_zero;
  logic [FIELD_W-1:0] field;

  assign field = haddr_i[FIELD_LSB +: FIELD_W];

  rwe_decode #(
    .FIELD_W(FIELD_W), .ARR_WS(ARR_WS), .WR_WS(WR_WS), .CNT_W(CNT_W)
  ) u_dec (
    .hsel_i    (hsel_i),
    .htrans_i  (htrans_i),
    .hwrite_i  (hwrite_i),
    .field_i   (field),
    .buf_hit_i (buf_hit_i),
    .ready_i   (hready_o),
    .accept_o  (accept),
    .kind_o    (kind),
    .wait_o    (wait_val)
  );

  rwe_phase_reg #(.AW(AW)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (hready_o),
    .accept_i   (accept),
    .kind_i     (kind),
    .addr_i     (haddr_i),
    .dp_valid_o (dp_valid),
    .dp_kind_o  (dp_kind),
    .dp_addr_o  (dp_addr)
  );

  rwe_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (wait_val),
    .active_i   (dp_valid),
    .zero_o     (cnt_zero)
  );

  rwe_resp #(.AW(AW), .DW(DW), .DATA_KEY(DATA_KEY)) u_resp (
    .dp_valid_i   (dp_valid),
    .dp_kind_i    (dp_kind),
    .dp_addr_i    (dp_addr),
    .done_i       (cnt_zero),
    .hready_o     (hready_o),
    .hrdata_o     (hrdata_o),
    .pf_inhibit_o (pf_inhibit_o),
    .pf_req_o     (pf_req_o)
  );

endmodule

// File: rtl/flash_rd_ws_emu_chk.sv
module flash_rd_ws_emu_chk #(
  parameter int DW      = 32,
  parameter int FIELD_W = 5,
  parameter int ARR_WS  = 2,
  parameter int WR_WS   = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsel_i,
  input logic [1:0]    htrans_i,
  input logic          hready_o,
  input logic [DW-1:0] hrdata_o,
  input logic          pf_inhibit_o,
  input logic          pf_req_o
);

  localparam int EMU_MAX = ARR_WS + (1 << FIELD_W) - 1;
  localparam int MAX_WS  = (EMU_MAX > WR_WS) ? EMU_MAX : WR_WS;
  localparam int RUN_W   = $clog2(MAX_WS + 2);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (hready_o) low_run <= '0;
    else if (low_run != {RUN_W{1'b1}}) low_run <= low_run + RUN_W'(1);
  end

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_o |-> (hrdata_o == '0)); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_o |-> (low_run < RUN_W'(MAX_WS))); // R4
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_o |=> $stable(pf_inhibit_o)); // R8
  AST_PF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_inhibit_o |-> !pf_req_o); // R9
  AST_PF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_o |=> !pf_req_o); // R9
  AST_PF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_o |-> hready_o); // R9
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_o && !(hsel_i && htrans_i[1])) |=> hready_o); // R11

endmodule

bind flash_rd_ws_emu flash_rd_ws_emu_chk #(
  .DW(DW), .FIELD_W(FIELD_W), .ARR_WS(ARR_WS), .WR_WS(WR_WS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hsel_i       (hsel_i),
  .htrans_i     (htrans_i),
  .hready_o     (hready_o),
  .hrdata_o     (hrdata_o),
  .pf_inhibit_o (pf_inhibit_o),
  .pf_req_o     (pf_req_o)
);

// File: tb/flash_rd_ws_emu_tb_top.sv
module flash_rd_ws_emu_tb_top;

  localparam int          ARR_WS = 2;
  localparam int          WR_WS  = 1;
  localparam logic [31:0] KEY    = 32'h5A3C_96E1;

  logic        clk;
  logic        rst_n;
  logic        hsel_i;
  logic [1:0]  htrans_i;
  logic        hwrite_i;
  logic [31:0] haddr_i;
  logic        buf_hit_i;
  logic        hready_o;
  logic [31:0] hrdata_o;
  logic        pf_inhibit_o;
  logic        pf_req_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  flash_rd_ws_emu dut_i (
    .clk(clk), .rst_n(rst_n), .hsel_i(hsel_i), .htrans_i(htrans_i),
    .hwrite_i(hwrite_i), .haddr_i(haddr_i), .buf_hit_i(buf_hit_i),
    .hready_o(hready_o), .hrdata_o(hrdata_o),
    .pf_inhibit_o(pf_inhibit_o), .pf_req_o(pf_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_ws(input bit wr, input bit seq, input logic [4:0] fld, input bit hit);
    if (wr)          return WR_WS;
    if (fld == 5'd0) return hit ? 0 : ARR_WS;
    if (seq)         return ARR_WS;
    return ARR_WS + int'(fld);
  endfunction

  function automatic string ws_req(input bit wr, input bit seq, input logic [4:0] fld, input bit hit);
    if (wr)          return "R6";
    if (fld == 5'd0) return hit ? "R2" : "R3";
    if (seq)         return "R5";
    return "R4";
  endfunction

  task automatic xfer(input bit wr, input bit seq, input logic [31:0] addr, input bit hit);
    logic [4:0] fld = addr[28:24];
    int  ew   = exp_ws(wr, seq, fld, hit);
    bit  einh = !wr && (fld != 0);
    bit  ereq = !wr && (fld == 0) && !hit;
    int  waits = 0;
    bit  bad_mid = 0;
    @(negedge clk);
    hsel_i = 1'b1; htrans_i = seq ? 2'b11 : 2'b10;
    hwrite_i = wr; haddr_i = addr; buf_hit_i = hit;
    @(negedge clk);
    // R10: scramble address-phase lines during the data phase
    hsel_i = 1'b0; htrans_i = 2'b00;
    haddr_i = $urandom; hwrite_i = 1'($urandom); buf_hit_i = 1'($urandom);
    while (!hready_o && waits < 100) begin
      if (pf_inhibit_o !== einh || pf_req_o !== 1'b0 || hrdata_o !== 32'd0) bad_mid = 1;
      waits++;
      @(negedge clk);
      haddr_i = $urandom; buf_hit_i = 1'($urandom);
    end
    chk(waits == ew, ws_req(wr, seq, fld, hit), waits, ew);
    chk(!bad_mid, "R8/R7 wait-state outputs", bad_mid, 0);
    chk(pf_inhibit_o == einh, "R8", pf_inhibit_o, einh);
    chk(pf_req_o == ereq, "R9", pf_req_o, ereq);
    chk(hrdata_o == (wr ? 32'd0 : (addr ^ KEY)), "R7", hrdata_o, wr ? 0 : (addr ^ KEY));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; hsel_i = 1'b0; htrans_i = 2'b00; hwrite_i = 1'b0;
    haddr_i = '0; buf_hit_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(hready_o && !pf_inhibit_o && !pf_req_o && hrdata_o == 0, "R1 in reset",
        {hready_o, pf_inhibit_o, pf_req_o}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hready_o && !pf_inhibit_o && !pf_req_o && hrdata_o == 0, "R1 after reset",
        {hready_o, pf_inhibit_o, pf_req_o}, 3'b100);

    // R11: idle, busy and deselected cycles
    hsel_i = 1'b1; htrans_i = 2'b00; haddr_i = 32'h1F00_0000;
    @(negedge clk); chk(hready_o && !pf_req_o, "R11 idle", hready_o, 1);
    htrans_i = 2'b01;
    @(negedge clk); chk(hready_o && !pf_inhibit_o, "R11 busy", hready_o, 1);
    hsel_i = 1'b0; htrans_i = 2'b10;
    @(negedge clk); chk(hready_o && !pf_inhibit_o, "R11 deselected", hready_o, 1);
    @(negedge clk); chk(hready_o && hrdata_o == 0, "R11 deselected data", hrdata_o, 0);
    htrans_i = 2'b00;

    // directed corners
    xfer(0, 0, 32'h0000_1234, 1);   // R2
    xfer(0, 0, 32'h0000_5678, 0);   // R3
    xfer(0, 1, 32'h0000_567C, 0);   // R3 seq
    xfer(0, 0, 32'h1F00_0040, 1);   // R4 max field, hit ignored
    xfer(0, 0, 32'h0100_0080, 0);   // R4 field 1
    xfer(0, 1, 32'h0100_0084, 1);   // R5 seq, hit ignored
    xfer(1, 0, 32'h1F00_0100, 1);   // R6 write with field
    xfer(1, 1, 32'h0000_0104, 0);   // R6 write seq
    xfer(0, 0, 32'hE000_0000, 1);   // R2 upper bits outside the field

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom;
      logic [4:0]  f = ($urandom % 2) ? 5'd0 : 5'($urandom % 32);
      a[28:24] = f;
      xfer(($urandom % 4) == 0, ($urandom % 3) == 0, a, 1'($urandom));
    end

    @(negedge clk);
    chk(hready_o && !pf_inhibit_o && !pf_req_o, "R11 final idle", hready_o, 1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule